// File: doc/BRIEF.md
# Prescaled Timer/Counter with Interrupt Flag

This block is the timer/counter of a small microcontroller. A free-running 6-bit prescaler advances once per instruction cycle and emits one tick every 64 instruction cycles. A loadable 4-bit up-counter is advanced by one of two sources, chosen by a source-select flip-flop. In timer mode the source is the prescaler tick. In event mode it is a rising edge on an external input pin, which is first passed through a two-stage synchronizer. When the counter rolls over from 15 to 0 it keeps counting. If the interrupt flag is clear at that moment, the roll-over sets the flag and raises a one-cycle interrupt request.

A single flag flip-flop serves both as the interrupt mask and as the pending indicator. Software sets and clears it through dedicated strobes, and reads it back through a test output. Loading the counter also restarts the prescaler. This gives software a known delay of 64 instruction cycles before the first timer-mode step.

All state advances only in system clock cycles where the instruction clock enable is high. Reset is synchronous and active high. Instruction decoding and interrupt vectoring are handled elsewhere.

Top module: `tmr_ctr_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, prescaler, source-select flip-flop, flag, synchronizer and `irq` all become 0.
- R2: In a clock cycle with `ce` low, no state changes: `cnt_q` and `flag_q` hold, and `irq` is 0.
- R3: The prescaler counts `ce` cycles modulo 64. In timer mode (source select 0), the counter increments at the 64th `ce` edge after the prescaler was last cleared, and again every 64 `ce` edges after that.
- R4: A `ce` edge with `ld_en` high writes `ld_data` into the counter and clears the prescaler to 0.
- R5: The counter counts upward and wraps from 15 to 0 on an increment, then keeps counting (15, 0, 1, ...).
- R6: In event mode (source select 1), `ext_in` is sampled on `ce` edges through two synchronizer stages. A low-to-high change that holds for at least 2 `ce` cycles high and 2 low adds exactly 1 to the counter. If `ext_in` rises before `ce` edge k, the counter changes at `ce` edge k+2.
- R7: `mode_set` makes the source select 1 and `mode_clr` makes it 0. If both are high in the same cycle, `mode_set` wins. In event mode, prescaler ticks do not change the counter.
- R8: A wrap that happens while the flag is 0 sets the flag to 1. In the same edge it makes `irq` high for exactly one clock cycle; this is the first cycle in which `flag_q` reads 1.
- R9: A wrap that happens while the flag is 1 leaves `irq` at 0 and the flag at 1.
- R10: `flag_set` sets the flag and `flag_clr` clears it. If both arrive in the same cycle, or if `flag_clr` coincides with a wrap that finds the flag at 0, the flag ends at 1.
- R11: If a load and a count event fall on the same `ce` edge, the load wins. The count event is lost, and it produces no wrap and no `irq`.
- R12: `flag_q` always shows the current flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Instruction-cycle clock enable |
| ld_en | input | 1 | Load strobe for the counter |
| ld_data | input | 4 | Value written into the counter on load |
| mode_set | input | 1 | Select event mode (external pin) |
| mode_clr | input | 1 | Select timer mode (prescaler tick) |
| flag_set | input | 1 | Set the interrupt flag |
| flag_clr | input | 1 | Clear the interrupt flag |
| ext_in | input | 1 | External event pin, asynchronous |
| flag_q | output | 1 | Flag test output |
| cnt_q | output | 4 | Current counter value |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions check several rules on every cycle:
- a load that sets the counter and restarts the prescaler;
- a wrap that lands on 0;
- the set-over-clear priority of the flag;
- a request that lasts one cycle, only with the flag set;
- a synchronized edge that is consumed after one `ce` cycle.

Other behaviour shows only through the bench's scenarios:
- the exact 64-cycle spacing of timer steps after a load;
- the masking of a second wrap;
- the loss of a count that collides with a load;
- the two-edge latency of external events;
- freezing when the enable is low.

These scenarios are checked against an independent cycle model across long random runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_EVENT = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic async_in,
  output logic rise
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh;

  generate
    for (genvar g = 0; g < SH_W; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[g] <= 1'b0;
        else if (ce) begin
          if (g == 0) sh[g] <= async_in;
          else        sh[g] <= sh[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (ce && rise) |=> !rise); // R6
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             clr,
  output logic             tick,
  output logic [PRE_W-1:0] pre_q
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (ce) begin
      if (clr)    pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = ce & ~clr & (pre_q == PRE_MAX);

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ce && clr) |=> (pre_q == '0)); // R4
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> $stable(pre_q)); // R2
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ce) begin
      if (ld)      cnt_q <= ld_data;
      else if (evt) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap = ce & evt & ~ld & (cnt_q == CNT_MAX);

  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ce && ld) |=> (cnt_q == $past(ld_data))); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic set,
  input  logic clr,
  input  logic wrap,
  output logic flag_q,
  output logic irq_q
);
  logic take;
  assign take = ce & wrap & ~flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= take;
      if (ce) begin
        if (set || take) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
      end
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (ce && set) |=> flag_q); // R10
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R8
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ce && wrap && flag_q) |=> !irq_q); // R9
endmodule

// File: rtl/tmr_ctr_top.sv
module tmr_ctr_top #(
  parameter int CNT_W       = 4,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             mode_set,
  input  logic             mode_clr,
  input  logic             flag_set,
  input  logic             flag_clr,
  input  logic             ext_in,
  output logic             flag_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq
);
  import tmr_pkg::*;

  cnt_src_e          src_q;
  logic              ext_rise;
  logic              pre_tick;
  logic [PRE_W-1:0]  pre_val;
  logic              cnt_evt;
  logic              cnt_wrap;

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_TIMER;
    else if (ce) begin
      if (mode_set)      src_q <= SRC_EVENT;
      else if (mode_clr) src_q <= SRC_TIMER;
    end
  end

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ce(ce), .async_in(ext_in), .rise(ext_rise)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .ce(ce), .clr(ld_en), .tick(pre_tick), .pre_q(pre_val)
  );

  assign cnt_evt = ce & ((src_q == SRC_EVENT) ? ext_rise : pre_tick);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ce(ce), .ld(ld_en), .ld_data(ld_data),
    .evt(cnt_evt), .cnt_q(cnt_q), .wrap(cnt_wrap)
  );

  tmr_flag u_flag (
    .clk(clk), .rst(rst), .ce(ce), .set(flag_set), .clr(flag_clr),
    .wrap(cnt_wrap), .flag_q(flag_q), .irq_q(irq)
  );

  AST_MODE_SET: assert property (@(posedge clk) disable iff (rst)
    (ce && mode_set) |=> (src_q == SRC_EVENT)); // R7
  AST_EVT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (ce && src_q == SRC_EVENT && !ext_rise && !ld_en) |=> $stable(cnt_q)); // R7
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> !irq); // R2
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pre_val != '1) |-> !pre_tick); // R3
endmodule

// File: tb/tb_tmr_ctr_top.sv
module tb_tmr_ctr_top;
  logic       clk = 1'b0;
  logic       rst, ce, ld_en, mode_set, mode_clr, flag_set, flag_clr, ext_in;
  logic [3:0] ld_data;
  logic       flag_q, irq;
  logic [3:0] cnt_q;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [5:0] m_pre;
  logic [3:0] m_cnt;
  logic       m_mode, m_flag, m_irq;
  logic [2:0] m_sh;

  always #2 clk = ~clk;

  tmr_ctr_top dut (
    .clk(clk), .rst(rst), .ce(ce), .ld_en(ld_en), .ld_data(ld_data),
    .mode_set(mode_set), .mode_clr(mode_clr), .flag_set(flag_set),
    .flag_clr(flag_clr), .ext_in(ext_in), .flag_q(flag_q), .cnt_q(cnt_q), .irq(irq)
  );

  task automatic model_step();
    logic tick, edg, evt, wrap;
    if (rst) begin
      m_pre = '0; m_cnt = '0; m_mode = 1'b0; m_flag = 1'b0; m_irq = 1'b0; m_sh = '0;
    end else begin
      m_irq = 1'b0;
      if (ce) begin
        tick = (m_pre == 6'd63);
        edg  = m_sh[1] & ~m_sh[2];
        evt  = m_mode ? edg : tick;
        wrap = evt && !ld_en && (m_cnt == 4'd15);
        m_irq = wrap && !m_flag;
        if (flag_set || (wrap && !m_flag)) m_flag = 1'b1;
        else if (flag_clr)                 m_flag = 1'b0;
        if (mode_set)      m_mode = 1'b1;
        else if (mode_clr) m_mode = 1'b0;
        if (ld_en)    m_cnt = ld_data;
        else if (evt) m_cnt = m_cnt + 4'd1;
        m_pre = ld_en ? 6'd0 : m_pre + 6'd1;
        m_sh  = {m_sh[1:0], ext_in};
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tcnt, string tflag, string tirq);
    check(tcnt, cnt_q, m_cnt);
    check(tflag, flag_q, m_flag);
    check(tirq, irq, m_irq);
  endtask

  task automatic idle_inputs();
    ld_en = 0; mode_set = 0; mode_clr = 0; flag_set = 0; flag_clr = 0;
  endtask

  task automatic load(logic [3:0] v);
    ld_en = 1; ld_data = v; cyc(); ld_en = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int hold;
    void'($urandom(32'd20240611));
    rst = 1; ce = 1; ext_in = 0; ld_data = 0; idle_inputs();
    @(negedge clk);
    cyc(); cyc();
    check("R1 cnt", cnt_q, 0); check("R1 flag", flag_q, 0); check("R1 irq", irq, 0);
    rst = 0;

    // R4 / R3: load restarts the prescaler; first step on the 64th ce edge
    load(4'd5);
    run(63);
    check("R4 cnt before tick", cnt_q, 5);
    cyc();
    check("R3 cnt after tick", cnt_q, 6);
    run(64);
    check("R3 periodic tick", cnt_q, 7);

    // R2: ce low freezes everything
    ce = 0; flag_set = 1;
    run(100);
    check("R2 cnt frozen", cnt_q, 7); check("R2 flag frozen", flag_q, 0);
    check("R2 irq low", irq, 0);
    flag_set = 0; ce = 1;

    // R5 / R8: wrap with flag clear raises one-cycle irq
    load(4'd15);
    run(63);
    check("R5 no early wrap", cnt_q, 15); check("R8 no early irq", irq, 0);
    cyc();
    check("R5 wrap to zero", cnt_q, 0); check("R8 irq pulse", irq, 1);
    check("R8 flag set", flag_q, 1);
    cyc();
    check("R8 irq one cycle", irq, 0);

    // R9: wrap with flag already set is masked
    load(4'd15);
    run(64);
    check("R9 wrap cnt", cnt_q, 0); check("R9 irq masked", irq, 0);
    check("R9 flag stays", flag_q, 1);

    // R10 / R12: flag clear, then set and clear together
    flag_clr = 1; cyc(); flag_clr = 0;
    check("R10 flag cleared", flag_q, 0); check("R12 test output", flag_q, m_flag);
    flag_set = 1; flag_clr = 1; cyc(); flag_set = 0; flag_clr = 0;
    check("R10 set wins", flag_q, 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    check("R12 test output low", flag_q, 0);

    // R11: load collides with the wrapping tick
    load(4'd15);
    run(63);
    ld_en = 1; ld_data = 4'd3; cyc(); ld_en = 0;
    check("R11 load wins", cnt_q, 3); check("R11 no irq", irq, 0);
    check("R11 flag untouched", flag_q, 0);

    // R7 / R6: event mode, set wins over clear; ticks ignored
    mode_set = 1; mode_clr = 1; cyc(); mode_set = 0; mode_clr = 0;
    load(4'd0);
    run(70);
    check("R7 tick ignored in event mode", cnt_q, 0);
    ext_in = 1; cyc(); cyc();
    check("R6 latency not yet", cnt_q, 0);
    cyc();
    check("R6 edge counted", cnt_q, 1);
    run(3); ext_in = 0; run(3);
    check("R6 counted once", cnt_q, 1);
    mode_clr = 1; cyc(); mode_clr = 0;

    // Random phase against the cycle model
    hold = 2;
    for (int i = 0; i < 4000; i++) begin
      ce       = ($urandom % 8) != 0;
      ld_en    = ($urandom % 97) == 0;
      ld_data  = 4'($urandom);
      mode_set = ($urandom % 300) == 0;
      mode_clr = ($urandom % 300) == 0;
      flag_set = ($urandom % 150) == 0;
      flag_clr = ($urandom % 40) == 0;
      hold--;
      if (hold <= 0) begin
        ext_in = ~ext_in;
        hold = 3 + int'($urandom % 5);
      end
      cyc();
      cmp_all("R5 cnt", "R12 flag", "R8 irq");
    end
    idle_inputs(); ce = 1;
    rst = 1; cyc(); rst = 0;
    check("R1 cnt after reset", cnt_q, 0); check("R1 flag after reset", flag_q, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule